// File: doc/BRIEF.md
# USB Suspend and Remote Wakeup Controller

This block handles the low-power side of a USB device. A counter watches the line for a continuous idle (J) state and raises a suspend status flag once the idle has lasted long enough. Resume signalling from the host sets a wakeup status flag. The device can also start its own resume from an external pin. Both wakeup sources are caught by edge-triggered capture flops that need no clock, so an event is held while the peripheral clock is stopped. A two-flop synchronizer then passes the event into the clock domain.

Remote wakeup is a two-step process. Software first arms the external pin by setting an enable bit. Later, when the system is ready to talk to the host, software sets a ready bit. Only the ready bit starts the K-state drive request to the transceiver. The request lasts a fixed number of timebase ticks, and then the ready bit clears itself.

Software reaches the block through a small register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `usb_suspend_wake`

## Requirements
- R1: After reset, every readable register reads 0, `irq` is 0 and `drive_k` is 0.
- R2: The suspend flag (status register at address 0, bit 0) sets at the clock edge that ends SUSP_MS*TICK_DIV consecutive cycles with `bus_idle` high. A single cycle with `bus_idle` low restarts the count.
- R3: The suspend flag sets at most once per idle period. If it is cleared while the line stays idle, it stays clear until activity is seen and a new full idle period has passed.
- R4: A rising edge on `bus_resume` sets the wakeup flag (status bit 1) at the third clock edge after the edge. This holds even when the pulse is shorter than a clock period and even when the clock is stopped at the moment of the edge.
- R5: A rising edge on `ext_resume` sets the wakeup flag with the same timing as R4, but only while the remote-wakeup enable bit is set (global register at address 5, bit 0). With the enable bit clear, the edge has no effect.
- R6: Writing 1s to address 2 sets mask bits, and writing 1s to address 3 clears them. The mask reads back at address 1, with bit 0 for suspend and bit 1 for wakeup. `irq` is high exactly when some flag and its mask bit are both set.
- R7: Writing address 4 clears each status flag whose bit is written as 1. Flags whose bits are written as 0 are unchanged.
- R8: A write to address 5 stores bit 0 as the enable. It stores bit 1 as the ready bit only if bit 0 of the same write is also 1. `drive_k` equals the ready bit, which reads back at address 5, bit 1.
- R9: Once set, the ready bit stays set for DRIVE_MS*TICK_DIV clock cycles and then clears by itself.
- R10: Writing address 5 with the ready bit or the enable bit as 0 ends the K-state request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; may be stopped during suspend |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_idle | input | 1 | Line is in J state, synchronous to `clk` |
| bus_resume | input | 1 | Resume signalling seen on the bus, asynchronous |
| ext_resume | input | 1 | External remote-wakeup pin, asynchronous |
| irq | output | 1 | Interrupt request |
| drive_k | output | 1 | Request to the transceiver to drive the K state |

## Verification
The bench breaks the idle run one cycle short of the limit. A counter that does not restart would then flag suspend early. It clears the suspend flag while the line stays idle; a design without a once-per-period guard would set the flag again. Resume pulses shorter than a clock period are sent while the clock is halted, which exposes a design that samples the pin with the clock and misses the event. The bench also tries remote wakeup with the enable bit clear, writes the ready bit without the enable, and aborts an active K drive. A controller that drives K on the pin edge, or ignores the enable, would show `drive_k` or the wakeup flag going high when the model expects it low.

// File: rtl/usb_suspend_wake.sv
module usb_suspend_wake #(
  parameter int TICK_DIV = 48000,
  parameter int SUSP_MS  = 3,
  parameter int DRIVE_MS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bus_idle,
  input  logic       bus_resume,
  input  logic       ext_resume,
  output logic       irq,
  output logic       drive_k
);
  localparam int TW = $clog2(TICK_DIV + 1);
  localparam int SW = $clog2(SUSP_MS + 1);
  localparam int DW = $clog2(DRIVE_MS + 1);
  localparam logic [2:0] A_STAT = 3'd0, A_MASK = 3'd1, A_MSET = 3'd2,
                         A_MCLR = 3'd3, A_FCLR = 3'd4, A_GLB  = 3'd5;

  logic          susp_flag, wake_flag, glb_en, glb_ready;
  logic [1:0]    mask;
  logic [TW-1:0] idle_cyc, drv_cyc;
  logic [SW-1:0] idle_ms;
  logic [DW-1:0] drv_ms;
  logic          idle_done;
  logic          cap_bus, cap_ext, wk_s1, wk_s2, wk_s3;

  wire wr_fclr = reg_wr && reg_addr == A_FCLR;
  wire wr_glb  = reg_wr && reg_addr == A_GLB;

  // idle timebase
  wire idle_wrap = idle_cyc == TW'(TICK_DIV - 1);
  wire susp_set  = bus_idle && !idle_done && idle_wrap && idle_ms == SW'(SUSP_MS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idle_cyc <= '0; idle_ms <= '0; idle_done <= 1'b0;
    end else if (!bus_idle) begin
      idle_cyc <= '0; idle_ms <= '0; idle_done <= 1'b0;
    end else if (!idle_done) begin
      if (idle_wrap) begin
        idle_cyc <= '0;
        idle_ms  <= idle_ms + 1'b1;
        if (idle_ms == SW'(SUSP_MS - 1)) idle_done <= 1'b1;
      end else
        idle_cyc <= idle_cyc + 1'b1;
    end

  // clockless capture of wakeup edges, released once synchronized
  wire cap_clr = wk_s2 | ~rst_n;

  always_ff @(posedge bus_resume or posedge cap_clr)
    if (cap_clr) cap_bus <= 1'b0;
    else         cap_bus <= 1'b1;

  always_ff @(posedge ext_resume or posedge cap_clr)
    if (cap_clr)     cap_ext <= 1'b0;
    else if (glb_en) cap_ext <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {wk_s3, wk_s2, wk_s1} <= 3'b000;
    else        {wk_s3, wk_s2, wk_s1} <= {wk_s2, wk_s1, cap_bus | cap_ext};

  wire wake_set = wk_s2 & ~wk_s3;

  // status and mask
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      susp_flag <= 1'b0; wake_flag <= 1'b0; mask <= 2'b00;
    end else begin
      susp_flag <= susp_set | (susp_flag & ~(wr_fclr & reg_wdata[0]));
      wake_flag <= wake_set | (wake_flag & ~(wr_fclr & reg_wdata[1]));
      if (reg_wr && reg_addr == A_MSET)      mask <= mask | reg_wdata[1:0];
      else if (reg_wr && reg_addr == A_MCLR) mask <= mask & ~reg_wdata[1:0];
    end

  // K-state drive window
  wire drv_wrap = drv_cyc == TW'(TICK_DIV - 1);
  wire drv_end  = glb_ready && drv_wrap && drv_ms == DW'(DRIVE_MS - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drv_cyc <= '0; drv_ms <= '0;
    end else if (!glb_ready || drv_end) begin
      drv_cyc <= '0; drv_ms <= '0;
    end else if (drv_wrap) begin
      drv_cyc <= '0; drv_ms <= drv_ms + 1'b1;
    end else
      drv_cyc <= drv_cyc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      glb_en <= 1'b0; glb_ready <= 1'b0;
    end else begin
      if (wr_glb) glb_en <= reg_wdata[0];
      if (drv_end)     glb_ready <= 1'b0;
      else if (wr_glb) glb_ready <= reg_wdata[0] & reg_wdata[1];
    end

  always_comb
    case (reg_addr)
      A_STAT:  reg_rdata = {6'd0, wake_flag, susp_flag};
      A_MASK:  reg_rdata = {6'd0, mask};
      A_GLB:   reg_rdata = {6'd0, glb_ready, glb_en};
      default: reg_rdata = 8'd0;
    endcase

  assign irq     = |({wake_flag, susp_flag} & mask);
  assign drive_k = glb_ready;

  a_r2_susp_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_flag) |-> $past(bus_idle));
  a_r4_wake_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> $past(wk_s2));
  a_r7_clear_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fclr && reg_wdata[0] && !susp_set) |=> !susp_flag);
  a_r8_k_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    drive_k |-> glb_en);
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_glb && !reg_wdata[0]) |=> !drive_k);
endmodule

// File: tb/usb_suspend_wake_test.sv
module usb_suspend_wake_test;
  localparam int TD = 20, SM = 3, DM = 10;
  localparam int NIDLE = SM * TD, NDRV = DM * TD;

  logic clk = 0, clk_run = 1, rst_n = 0;
  logic reg_wr = 0, bus_idle = 0, bus_resume = 0, ext_resume = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic irq, drive_k;
  int tests = 0, fails = 0;

  usb_suspend_wake #(.TICK_DIV(TD), .SUSP_MS(SM), .DRIVE_MS(DM)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_idle(bus_idle),
    .bus_resume(bus_resume), .ext_resume(ext_resume), .irq(irq), .drive_k(drive_k));

  always begin #5; if (clk_run) clk = ~clk; end

  // reference model
  int m_susp = 0, m_wake = 0, m_mask = 0, m_en = 0, m_ready = 0;
  int idle_run = 0, drv_run = 0, pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_susp = 0; m_wake = 0; m_mask = 0; m_en = 0; m_ready = 0;
      idle_run = 0; drv_run = 0; pend = 0;
    end else begin
      automatic bit expire = (m_ready != 0) && (drv_run + 1 == NDRV);
      if (m_ready != 0) drv_run = expire ? 0 : drv_run + 1; else drv_run = 0;
      if (reg_wr) case (reg_addr)
        3'd2: m_mask = m_mask | reg_wdata[1:0];
        3'd3: m_mask = m_mask & ~int'(reg_wdata[1:0]);
        3'd4: begin
          if (reg_wdata[0]) m_susp = 0;
          if (reg_wdata[1]) m_wake = 0;
        end
        3'd5: begin m_en = reg_wdata[0]; m_ready = reg_wdata[0] & reg_wdata[1]; end
        default: ;
      endcase
      if (expire) m_ready = 0;
      if (bus_idle) begin
        if (idle_run < NIDLE) begin
          idle_run++;
          if (idle_run == NIDLE) m_susp = 1;
        end
      end else idle_run = 0;
      if (pend > 0) begin pend--; if (pend == 0) m_wake = 1; end
    end
  end

  function automatic int exp_irq();
    return ((m_susp & m_mask) | ((m_wake << 1) & m_mask)) != 0;
  endfunction

  always @(negedge clk) if (rst_n) begin
    tests++;
    if (irq !== 1'(exp_irq())) begin
      fails++; $display("FAIL R6 irq actual %0b expected %0d", irq, exp_irq());
    end
    tests++;
    if (drive_k !== 1'(m_ready)) begin
      fails++; $display("FAIL R9 drive_k actual %0b expected %0d", drive_k, m_ready);
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, string tag);
    int e;
    @(negedge clk); reg_addr = a; #1;
    case (a)
      3'd0: e = m_susp | (m_wake << 1);
      3'd1: e = m_mask;
      3'd5: e = m_en | (m_ready << 1);
      default: e = 0;
    endcase
    tests++;
    if (reg_rdata !== 8'(e)) begin
      fails++; $display("FAIL %s addr %0d actual %0h expected %0h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic pulse_bus(bit halt);
    @(negedge clk);
    if (halt) clk_run = 0;
    #2 bus_resume = 1; #1 bus_resume = 0;
    pend = 3;
    if (halt) begin #40 clk_run = 1; end
  endtask

  task automatic pulse_ext();
    @(negedge clk);
    #2 ext_resume = 1; #1 ext_resume = 0;
    if (m_en != 0) pend = 3;
  endtask

  initial begin
    #100000;
    fails++; $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1;
    // R1 reset state
    rd(0, "R1"); rd(1, "R1"); rd(5, "R1");
    tests++; if (irq !== 0 || drive_k !== 0) begin fails++; $display("FAIL R1 outputs actual %0b%0b expected 00", irq, drive_k); end
    // R6 mask set/clear
    wr(2, 8'h03); rd(1, "R6");
    wr(3, 8'h02); rd(1, "R6");
    wr(2, 8'h02); rd(1, "R6");
    // R2 idle run broken one short, then full
    bus_idle = 1; cyc(NIDLE - 2); rd(0, "R2");
    bus_idle = 0; cyc(1); bus_idle = 1;
    cyc(NIDLE - 3); rd(0, "R2"); cyc(4); rd(0, "R2");
    // R7 clearing the other bit leaves suspend set
    wr(4, 8'h02); rd(0, "R7");
    // R3 no re-set during the same idle period
    wr(4, 8'h01); cyc(NIDLE + 10); rd(0, "R3");
    bus_idle = 0; cyc(2); bus_idle = 1; cyc(NIDLE + 2); rd(0, "R3");
    wr(4, 8'h01); bus_idle = 0;
    // R4 resume with clock halted
    pulse_bus(1); cyc(4); rd(0, "R4");
    wr(4, 8'h02); rd(0, "R7");
    pulse_bus(0); cyc(4); rd(0, "R4"); wr(4, 8'h02);
    // R5 external pin gated by enable
    pulse_ext(); cyc(6); rd(0, "R5");
    wr(5, 8'h01); rd(5, "R5");
    pulse_ext(); cyc(5); rd(0, "R5"); wr(4, 8'h02); rd(0, "R5");
    // R8 ready without enable refused
    wr(5, 8'h02); rd(5, "R8"); cyc(3);
    wr(5, 8'h03); rd(5, "R8");
    // R9 full drive window and self clear
    cyc(NDRV + 10); rd(5, "R9");
    // R10 abort by clearing ready, then by clearing enable
    wr(5, 8'h03); cyc(50); wr(5, 8'h01); rd(5, "R10");
    wr(5, 8'h03); cyc(30); wr(5, 8'h00); rd(5, "R10"); cyc(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule